// File: doc/BRIEF.md
# Link Frame Block Cadence Scheduler

The scheduler decides, once per link frame, how many sample blocks one outbound stream places in that frame. The link runs at a fixed 48 kHz frame rate. Streams whose sample rate is a multiple, a sub-multiple or two thirds of 48 kHz follow a simple per-frame pattern. Streams based on 44.1 kHz follow a fixed 160-frame cadence that carries exactly 147 non-empty frames. A divider or multiplier is then applied on top of that cadence.

The controller raises the frame strobe for one clock at each frame start. The block count for that frame appears on the output one clock later and stays put until the next strobe. This is well before the stream's slot in the frame is reached. Each stream uses its own instance, so streams at unrelated rates run side by side without sharing state. When the configuration changes, or the enable drops, the pattern restarts from its first frame.

Top module: `blk_cadence_sched`

## Requirements
- R1: While `en` is low, `blk_cnt` reads 0 from the clock after `en` is sampled low, and strobes have no effect. After reset, `blk_cnt` is 0.
- R2: `blk_cnt` changes only on the clock edge that samples `frame_stb` high with `en` high. It takes that frame's count on that edge and holds it on every later clock until the next such edge.
- R3: With `base_sel`=0 (48 kHz base) and `rate_mode`=2'b00 (multiply), every frame carries `factor` blocks. A `factor` of 0 behaves as 1. Over 160 frames this gives 160·n blocks.
- R4: With `base_sel`=0 and `rate_mode`=2'b01 (divide by n), the first frame carries 1 block and the next n-1 frames carry 0, repeating. Over 160 frames this gives ceil(160/n) blocks.
- R5: With `rate_mode`=2'b10 (two thirds) on the 48 kHz base, frames repeat the pattern 1,1,0. Over 160 frames this gives 107 blocks.
- R6: With `base_sel`=1 (44.1 kHz base), frames form 13 runs of non-empty frames with lengths 12,11,11 repeated four times and then 11. Each run is followed by one empty frame. This gives 147 non-empty frames in every 160.
- R7: On the 44.1 kHz base in multiply mode, each non-empty cadence frame carries n blocks and each empty frame carries 0. Over 160 frames this gives 147·n blocks.
- R8: On the 44.1 kHz base in divide or two-thirds mode, the divider phase advances only on non-empty cadence frames. Divide-by-n then sends 147 blocks every 160·n frames, and two thirds sends 98 blocks per 160 frames.
- R9: A change to `base_sel`, `rate_mode` or `factor`, or `en` going low, restarts the pattern. The next strobe is then the first frame of the first run, with the divider phase at zero. `rate_mode`=2'b11 behaves as multiply.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Stream enable; low clears the count and the pattern |
| frame_stb | input | 1 | One-clock pulse at each link frame start |
| base_sel | input | 1 | 0: 48 kHz base, 1: 44.1 kHz base |
| rate_mode | input | 2 | 00 multiply, 01 divide, 10 two thirds, 11 multiply |
| factor | input | FACT_W | Multiplier or divider n (0 treated as 1) |
| blk_cnt | output | CNT_W | Blocks carried by the current frame |

## Verification
Every count is due exactly one clock after the edge that samples the strobe. The bench raises the strobe on a falling edge and reads the count at the next falling edge. It reads the count again two clocks later to confirm that it held. A configuration change is applied between strobes. The bench then leaves at least one idle clock before the next strobe, so the restart has already taken effect when the first new frame is sampled. Per-frame counts are compared against a bench model indexed by the frame number since the last restart. Whole-period totals over 160 or 160·n frames are also compared against closed-form values.

// File: rtl/sched_pkg.sv
package sched_pkg;

  typedef enum logic [1:0] {
    RM_MUL  = 2'b00,
    RM_DIV  = 2'b01,
    RM_TWO3 = 2'b10,
    RM_RSV  = 2'b11
  } rate_mode_e;

  // index of the last run in the 160-frame cadence
  localparam logic [3:0] CAD_LAST = 4'd12;

  // runs 0,3,6,9 are twelve frames long, all others eleven
  function automatic logic [3:0] run_len(input logic [3:0] idx);
    if ((idx == 4'd0) || (idx == 4'd3) || (idx == 4'd6) || (idx == 4'd9))
      run_len = 4'd12;
    else
      run_len = 4'd11;
  endfunction

endpackage

// File: rtl/sched_cadence.sv
module sched_cadence
  import sched_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic step,
  output logic ne
);

  logic [3:0] run_q, run_d;
  logic [3:0] pos_q, pos_d;
  logic [3:0] run_cur, pos_cur;
  logic       gap;

  // effective position of the frame now starting
  always_comb begin
    run_cur = restart ? 4'd0 : run_q;
    pos_cur = restart ? 4'd0 : pos_q;
    gap     = (pos_cur == run_len(run_cur));
    ne      = ~gap;
  end

  always_comb begin
    run_d = run_cur;
    pos_d = pos_cur;
    if (step) begin
      if (gap) begin
        pos_d = 4'd0;
        run_d = (run_cur == CAD_LAST) ? 4'd0 : run_cur + 4'd1;
      end else begin
        pos_d = pos_cur + 4'd1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 4'd0;
      pos_q <= 4'd0;
    end else begin
      run_q <= run_d;
      pos_q <= pos_d;
    end
  end

endmodule

// File: rtl/sched_divider.sv
module sched_divider
  import sched_pkg::*;
#(
  parameter int FACT_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic              step,
  input  rate_mode_e        mode,
  input  logic [FACT_W-1:0] fac_n,
  output logic              hit
);

  localparam logic [FACT_W-1:0] THREE = FACT_W'(3);
  localparam logic [FACT_W-1:0] TWO   = FACT_W'(2);

  logic [FACT_W-1:0] ph_q, ph_d, ph_cur, modulus;
  logic              counting;

  always_comb begin
    ph_cur   = restart ? '0 : ph_q;
    counting = (mode == RM_DIV) || (mode == RM_TWO3);
    modulus  = (mode == RM_TWO3) ? THREE : fac_n;
    unique case (mode)
      RM_DIV:  hit = (ph_cur == '0);
      RM_TWO3: hit = (ph_cur != TWO);
      default: hit = 1'b1;
    endcase
  end

  always_comb begin
    ph_d = ph_cur;
    if (step && counting)
      ph_d = (ph_cur == modulus - FACT_W'(1)) ? '0 : ph_cur + FACT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= '0;
    else        ph_q <= ph_d;
  end

endmodule

// File: rtl/blk_cadence_sched.sv
module blk_cadence_sched
  import sched_pkg::*;
#(
  parameter int FACT_W = 3,
  parameter int CNT_W  = FACT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              frame_stb,
  input  logic              base_sel,
  input  logic [1:0]        rate_mode,
  input  logic [FACT_W-1:0] factor,
  output logic [CNT_W-1:0]  blk_cnt
);

  localparam int CFG_W = 1 + 2 + FACT_W;

  logic [CFG_W-1:0]  cfg, cfg_q;
  logic              restart, step, div_step;
  logic              cad_ne, frame_ne, div_hit;
  logic [FACT_W-1:0] fac_n;
  rate_mode_e        mode;
  logic [CNT_W-1:0]  cnt_now, cnt_d, cnt_q;

  always_comb begin
    cfg      = {base_sel, rate_mode, factor};
    restart  = ~en | (cfg != cfg_q);
    step     = en & frame_stb;
    mode     = rate_mode_e'(rate_mode);
    fac_n    = (factor == '0) ? FACT_W'(1) : factor;
    frame_ne = base_sel ? cad_ne : 1'b1;
    div_step = step & frame_ne;
  end

  sched_cadence u_cad (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (restart),
    .step    (step),
    .ne      (cad_ne)
  );

  sched_divider #(.FACT_W(FACT_W)) u_div (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (restart),
    .step    (div_step),
    .mode    (mode),
    .fac_n   (fac_n),
    .hit     (div_hit)
  );

  always_comb begin
    if (!(frame_ne && div_hit))
      cnt_now = '0;
    else if ((mode == RM_DIV) || (mode == RM_TWO3))
      cnt_now = CNT_W'(1);
    else
      cnt_now = CNT_W'(fac_n);
  end

  always_comb begin
    cnt_d = cnt_q;
    if (!en)      cnt_d = '0;
    else if (step) cnt_d = cnt_now;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      cfg_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      cfg_q <= cfg;
    end
  end

  assign blk_cnt = cnt_q;

endmodule

// File: rtl/blk_cadence_sched_chk.sv
module blk_cadence_sched_chk #(
  parameter int FACT_W = 3,
  parameter int CNT_W  = FACT_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              en,
  input logic              frame_stb,
  input logic              base_sel,
  input logic [1:0]        rate_mode,
  input logic [FACT_W-1:0] factor,
  input logic [CNT_W-1:0]  blk_cnt
);

  a_r1_off_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (blk_cnt == '0));

  a_r2_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !frame_stb) |=> $stable(blk_cnt));

  a_r3_mul48_count: assert property (@(posedge clk) disable iff (!rst_n)
    (en && frame_stb && !base_sel && rate_mode == 2'b00) |=>
      (blk_cnt == (($past(factor) == '0) ? CNT_W'(1) : CNT_W'($past(factor)))));

  a_r4_single_when_div: assert property (@(posedge clk) disable iff (!rst_n)
    (en && frame_stb && (rate_mode == 2'b01 || rate_mode == 2'b10)) |=>
      (blk_cnt <= CNT_W'(1)));

  a_r9_first_frame_full: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(en) && frame_stb) |=> (blk_cnt != '0));

endmodule

bind blk_cadence_sched blk_cadence_sched_chk #(.FACT_W(FACT_W), .CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .en        (en),
  .frame_stb (frame_stb),
  .base_sel  (base_sel),
  .rate_mode (rate_mode),
  .factor    (factor),
  .blk_cnt   (blk_cnt)
);

// File: tb/blk_cadence_sched_tb.sv
module blk_cadence_sched_tb;

  localparam int CLK_P  = 10;
  localparam int FACT_W = 3;
  localparam int CNT_W  = 3;

  logic              clk;
  logic              rst_n;
  logic              en;
  logic              frame_stb;
  logic              base_sel;
  logic [1:0]        rate_mode;
  logic [FACT_W-1:0] factor;
  logic [CNT_W-1:0]  blk_cnt;

  int total_chk;
  int bad_chk;
  int k_fr;
  int ne_seen;
  bit done;

  blk_cadence_sched #(.FACT_W(FACT_W), .CNT_W(CNT_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .en(en), .frame_stb(frame_stb),
    .base_sel(base_sel), .rate_mode(rate_mode), .factor(factor),
    .blk_cnt(blk_cnt)
  );

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    total_chk++;
    if (act != exp) begin
      bad_chk++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // cadence model: is frame p (0..159) of the 44.1 kHz period non-empty
  function automatic bit cad_ne(input int p);
    int q;
    q = p;
    for (int r = 0; r < 13; r++) begin
      int len;
      len = ((r % 3 == 0) && (r != 12)) ? 12 : 11;
      if (q < len) return 1'b1;
      if (q == len) return 1'b0;
      q = q - len - 1;
    end
    return 1'b0;
  endfunction

  function automatic int exp_cnt(input bit b, input int m, input int f,
                                 input int k, input int nes);
    int nf, idx;
    bit ne;
    nf  = (f == 0) ? 1 : f;
    ne  = b ? cad_ne(k % 160) : 1'b1;
    idx = b ? nes : k;
    if (!ne) return 0;
    case (m)
      1:       return (idx % nf == 0) ? 1 : 0;
      2:       return (idx % 3 != 2) ? 1 : 0;
      default: return nf;
    endcase
  endfunction

  task automatic set_cfg(input bit b, input int m, input int f);
    @(negedge clk);
    base_sel  = b;
    rate_mode = m[1:0];
    factor    = f[FACT_W-1:0];
    k_fr      = 0;
    ne_seen   = 0;
    @(negedge clk);
  endtask

  task automatic one_frame(input string req, output int got);
    int e;
    @(negedge clk) frame_stb = 1'b1;
    @(negedge clk) frame_stb = 1'b0;
    got = int'(blk_cnt);
    e = exp_cnt(base_sel, int'(rate_mode), int'(factor), k_fr, ne_seen);
    chk(req, got, e);
    if (base_sel && cad_ne(k_fr % 160)) ne_seen++;
    k_fr++;
    @(negedge clk);
    @(negedge clk);
    chk("R2 hold", int'(blk_cnt), got);
  endtask

  task automatic run_frames(input string req, input int n, output int sum);
    int g;
    sum = 0;
    for (int i = 0; i < n; i++) begin
      one_frame(req, g);
      sum += g;
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total_chk, bad_chk);
      $finish;
    end
  endtask

  initial begin
    #(CLK_P * 150000);
    total_chk++;
    bad_chk++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    int s, g;
    void'($urandom(32'd2024));
    total_chk = 0; bad_chk = 0; done = 1'b0; k_fr = 0; ne_seen = 0;
    rst_n = 1'b0; en = 1'b0; frame_stb = 1'b0;
    base_sel = 1'b0; rate_mode = 2'b00; factor = 3'd1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset", int'(blk_cnt), 0);
    en = 1'b1;

    // R3: 48 kHz multiples
    set_cfg(0, 0, 2); run_frames("R3 x2", 160, s); chk("R3 total x2", s, 320);
    set_cfg(0, 0, 4); run_frames("R3 x4", 160, s); chk("R3 total x4", s, 640);
    set_cfg(0, 0, 0); run_frames("R3 x0", 160, s); chk("R3 total f0", s, 160);
    // R4: 48 kHz sub-multiples
    set_cfg(0, 1, 6); run_frames("R4 /6", 160, s); chk("R4 total /6", s, 27);
    set_cfg(0, 1, 4); run_frames("R4 /4", 160, s); chk("R4 total /4", s, 40);
    set_cfg(0, 1, 3); run_frames("R4 /3", 160, s); chk("R4 total /3", s, 54);
    // R5: two thirds
    set_cfg(0, 2, 1); run_frames("R5 2/3", 160, s); chk("R5 total", s, 107);
    // R6/R7: 44.1 kHz cadence and multiples
    set_cfg(1, 0, 1); run_frames("R6 cad", 160, s); chk("R6 total", s, 147);
    set_cfg(1, 0, 2); run_frames("R7 x2", 160, s); chk("R7 total x2", s, 294);
    set_cfg(1, 0, 4); run_frames("R7 x4", 160, s); chk("R7 total x4", s, 588);
    // R8: 44.1 kHz sub-multiples and two thirds
    set_cfg(1, 1, 2); run_frames("R8 /2", 320, s); chk("R8 total /2", s, 147);
    set_cfg(1, 1, 4); run_frames("R8 /4", 640, s); chk("R8 total /4", s, 147);
    set_cfg(1, 2, 1); run_frames("R8 2/3", 160, s); chk("R8 total 2/3", s, 98);

    // R1 and R9: enable drop mid-cadence, strobes ignored while off
    set_cfg(1, 0, 1); run_frames("R9 pre", 30, s);
    @(negedge clk) en = 1'b0;
    @(negedge clk);
    chk("R1 off", int'(blk_cnt), 0);
    @(negedge clk) frame_stb = 1'b1;
    @(negedge clk) frame_stb = 1'b0;
    chk("R1 stb ignored", int'(blk_cnt), 0);
    @(negedge clk) en = 1'b1;
    k_fr = 0; ne_seen = 0;
    @(negedge clk);
    run_frames("R9 after en", 40, s);

    // R9: configuration change mid-run restarts cadence and divider
    set_cfg(1, 1, 4); run_frames("R9 pre cfg", 25, s);
    set_cfg(1, 1, 3); run_frames("R9 new cfg", 60, s);
    set_cfg(0, 3, 3); run_frames("R9 mode 11", 10, s); chk("R9 mode11 total", s, 30);

    // random configurations
    for (int r = 0; r < 14; r++) begin
      bit rb;
      int rm, rf, rn;
      rb = 1'($urandom % 2);
      rm = int'($urandom % 4);
      rf = int'($urandom % 8);
      rn = 20 + int'($urandom % 80);
      set_cfg(rb, rm, rf);
      run_frames("RND", rn, g);
    end

    finish_run();
  end

endmodule